// File: doc/BRIEF.md
# Branch and Jump Target Resolver

This block settles where a 64-bit integer pipeline goes next when a control-transfer instruction reaches it. Each cycle in which the input strobe is high it takes a decoded transfer kind, a 3-bit register-condition code, an externally computed condition-code verdict, the source register value, the second operand (a register or a sign-extended 13-bit immediate, already selected), the current PC, the sequential next-next PC and a sign-extended displacement. One cycle later it presents the resolved next-next PC, an optional link write (destination select and value), and two fault flags: misaligned jump target and illegal condition encoding.

Branches on register contents compare the whole 64-bit register, as a signed number, against zero. Calls and PC-relative branches add the displacement to the current PC. Jump-and-link and return compute a register-plus-operand target and check its word alignment. A misaligned target suppresses every architectural effect of the instruction, so the fault handler sees the sequential path untouched.

Top module: `xfer_resolver`

## Requirements
- R1: With kind 2 (register branch), condition code 1 takes when the register is zero, 5 when nonzero, 3 when negative, 7 when zero or positive, 2 when zero or negative, 6 when strictly positive; the register is read as a signed 64-bit value.
- R2: Register-branch condition codes 0 and 4 raise `illegal_o` for that result and never take the branch; the next-next PC stays sequential.
- R3: A taken branch (kind 2 with a true condition, or kind 1 with `cc_taken_i` high) drives `nnpc_o` to `pc_i + disp_i`.
- R4: A branch that is not taken drives `nnpc_o` to `seq_nnpc_i` and makes no link write.
- R5: Kind 3 (call) writes the current PC to link register 15 and drives `nnpc_o` to `pc_i + disp_i`.
- R6: Kind 4 (jump-and-link) drives `nnpc_o` to `rs1_i + opnd_i` and writes the current PC to the register selected by `rd_sel_i`.
- R7: Kind 5 (return) drives `nnpc_o` to `rs1_i + opnd_i` and makes no link write.
- R8: For kinds 4 and 5, a target whose bits [1:0] are not both zero raises `misalign_o`; the result then carries no link write and `nnpc_o` equals `seq_nnpc_i`.
- R9: Every output is registered: a strobe on `in_valid_i` produces `out_valid_o` exactly one cycle later, and `link_we_o`, `misalign_o` and `illegal_o` are low whenever `out_valid_o` is low.
- R10: During reset all outputs are zero.
- R11: Kind 0 and the unused kinds 6 and 7 resolve to the sequential next-next PC with no link write and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input strobe |
| kind_i | input | 3 | Transfer kind: 0 none, 1 cc branch, 2 register branch, 3 call, 4 jump-and-link, 5 return |
| cond_i | input | 3 | Register-branch condition code |
| cc_taken_i | input | 1 | Precomputed verdict for condition-code branches |
| rs1_i | input | 64 | Source register value |
| opnd_i | input | 64 | Second operand |
| pc_i | input | 64 | Current PC |
| seq_nnpc_i | input | 64 | Sequential next-next PC |
| disp_i | input | 64 | Sign-extended displacement |
| rd_sel_i | input | 5 | Destination register for jump-and-link |
| out_valid_o | output | 1 | Result valid |
| nnpc_o | output | 64 | Resolved next-next PC |
| link_we_o | output | 1 | Link write enable |
| link_sel_o | output | 5 | Link destination register |
| link_val_o | output | 64 | Link value |
| misalign_o | output | 1 | Misaligned jump target fault |
| illegal_o | output | 1 | Reserved condition encoding |

## Verification
Assertions watch on every cycle the one-cycle strobe latency, that fault and link flags appear only with a valid result, that a fault never coexists with a link write, that an illegal encoding leaves the sequential path and never takes, and that calls always link to register 15 while returns never link. The signed comparisons at the edges of the range, the exact target arithmetic for negative operands and displacements, and the choice between the two misaligned low-bit patterns are visible only through the bench's scenarios, whose scoreboard predicts each result from the requirements and compares it field by field.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [2:0] {
        XK_NONE  = 3'd0,
        XK_CCBR  = 3'd1,
        XK_REGBR = 3'd2,
        XK_CALL  = 3'd3,
        XK_JMPL  = 3'd4,
        XK_RET   = 3'd5,
        XK_UNU6  = 3'd6,
        XK_UNU7  = 3'd7
    } xfer_kind_e;

    localparam int unsigned COND_W = 3;
endpackage

// File: rtl/regcond_eval.sv
module regcond_eval
    import xfer_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0]      val_i,
    input  logic [COND_W-1:0] code_i,
    output logic              taken_o,
    output logic              reserved_o
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (val_i == '0);
    assign is_neg  = val_i[W-1];

    always_comb begin
        taken_o    = 1'b0;
        reserved_o = 1'b0;
        unique case (code_i)
            3'd1:    taken_o = is_zero;
            3'd2:    taken_o = is_zero | is_neg;
            3'd3:    taken_o = is_neg;
            3'd5:    taken_o = !is_zero;
            3'd6:    taken_o = !is_zero & !is_neg;
            3'd7:    taken_o = !is_neg;
            default: reserved_o = 1'b1;
        endcase
    end

    // R2: a reserved code never reports a taken branch
    always_comb begin
        assert_reserved_not_taken_R2: assert (!(reserved_o && taken_o));
    end
endmodule

// File: rtl/target_calc.sv
module target_calc #(
    parameter int unsigned W          = 64,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] offs_i,
    output logic [W-1:0] target_o,
    output logic         misaligned_o
);
    assign target_o     = base_i + offs_i;
    assign misaligned_o = |target_o[ALIGN_BITS-1:0];
endmodule

// File: rtl/xfer_resolver.sv
module xfer_resolver
    import xfer_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned RIDX_W     = 5,
    parameter int unsigned LINK_REG   = 15,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [2:0]        kind_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              cc_taken_i,
    input  logic [XLEN-1:0]   rs1_i,
    input  logic [XLEN-1:0]   opnd_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   seq_nnpc_i,
    input  logic [XLEN-1:0]   disp_i,
    input  logic [RIDX_W-1:0] rd_sel_i,
    output logic              out_valid_o,
    output logic [XLEN-1:0]   nnpc_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_sel_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic              misalign_o,
    output logic              illegal_o
);
    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   nnpc;
        logic              link_we;
        logic [RIDX_W-1:0] link_sel;
        logic [XLEN-1:0]   link_val;
        logic              misalign;
        logic              illegal;
    } res_t;

    res_t res_d, res_q;

    logic            rc_taken;
    logic            rc_reserved;
    logic [XLEN-1:0] jmp_tgt;
    logic            jmp_bad;
    logic [XLEN-1:0] rel_tgt;
    xfer_kind_e      kind;

    assign kind    = xfer_kind_e'(kind_i);
    assign rel_tgt = pc_i + disp_i;

    regcond_eval #(.W(XLEN)) u_cond (
        .val_i      (rs1_i),
        .code_i     (cond_i),
        .taken_o    (rc_taken),
        .reserved_o (rc_reserved)
    );

    target_calc #(.W(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_tgt (
        .base_i       (rs1_i),
        .offs_i       (opnd_i),
        .target_o     (jmp_tgt),
        .misaligned_o (jmp_bad)
    );

    always_comb begin
        res_d          = res_q;
        res_d.valid    = in_valid_i;
        res_d.link_we  = 1'b0;
        res_d.misalign = 1'b0;
        res_d.illegal  = 1'b0;
        if (in_valid_i) begin
            res_d.nnpc = seq_nnpc_i;
            unique case (kind)
                XK_CCBR: begin
                    if (cc_taken_i) res_d.nnpc = rel_tgt;
                end
                XK_REGBR: begin
                    if (rc_reserved)   res_d.illegal = 1'b1;
                    else if (rc_taken) res_d.nnpc    = rel_tgt;
                end
                XK_CALL: begin
                    res_d.nnpc     = rel_tgt;
                    res_d.link_we  = 1'b1;
                    res_d.link_sel = LINK_IDX;
                    res_d.link_val = pc_i;
                end
                XK_JMPL, XK_RET: begin
                    if (jmp_bad) begin
                        res_d.misalign = 1'b1;
                    end else begin
                        res_d.nnpc = jmp_tgt;
                        if (kind == XK_JMPL) begin
                            res_d.link_we  = 1'b1;
                            res_d.link_sel = rd_sel_i;
                            res_d.link_val = pc_i;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid_o = res_q.valid;
    assign nnpc_o      = res_q.nnpc;
    assign link_we_o   = res_q.link_we;
    assign link_sel_o  = res_q.link_sel;
    assign link_val_o  = res_q.link_val;
    assign misalign_o  = res_q.misalign;
    assign illegal_o   = res_q.illegal;

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);
    assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we_o || misalign_o || illegal_o) |-> out_valid_o);
    assert_fault_no_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (!link_we_o && nnpc_o == $past(seq_nnpc_i)));
    assert_illegal_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> nnpc_o == $past(seq_nnpc_i));
    assert_call_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && kind_i == 3'd3) |=> (link_we_o && link_sel_o == LINK_IDX));
    assert_ret_no_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && kind_i == 3'd5) |=> !link_we_o);
endmodule

// File: tb/test_xfer_resolver.sv
module test_xfer_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [2:0]  cond_i = '0;
    logic        cc_taken_i = 1'b0;
    logic [63:0] rs1_i = '0, opnd_i = '0, pc_i = '0, seq_nnpc_i = '0, disp_i = '0;
    logic [4:0]  rd_sel_i = '0;
    logic        out_valid_o, link_we_o, misalign_o, illegal_o;
    logic [63:0] nnpc_o, link_val_o;
    logic [4:0]  link_sel_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] nnpc;
        logic        we;
        logic [4:0]  sel;
        logic [63:0] val;
        logic        mis;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    xfer_resolver i_xfer_resolver (.*);

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic send(input logic [2:0] k, input logic [2:0] c, input logic cct,
                        input logic [63:0] rs1, input logic [63:0] op,
                        input logic [63:0] pc, input logic [63:0] seq,
                        input logic [63:0] disp, input logic [4:0] rd,
                        input string tag);
        exp_t e;
        logic tk;
        logic [63:0] tg;
        @(negedge clk);
        in_valid_i = 1'b1; kind_i = k; cond_i = c; cc_taken_i = cct;
        rs1_i = rs1; opnd_i = op; pc_i = pc; seq_nnpc_i = seq; disp_i = disp; rd_sel_i = rd;
        e.nnpc = seq; e.we = 1'b0; e.sel = '0; e.val = '0; e.mis = 1'b0; e.ill = 1'b0; e.tag = tag;
        tg = rs1 + op;
        case (k)
            3'd1: if (cct) e.nnpc = pc + disp;
            3'd2: begin
                case (c)
                    3'd1: tk = ($signed(rs1) == 0);
                    3'd2: tk = ($signed(rs1) <= 0);
                    3'd3: tk = ($signed(rs1) < 0);
                    3'd5: tk = ($signed(rs1) != 0);
                    3'd6: tk = ($signed(rs1) > 0);
                    3'd7: tk = ($signed(rs1) >= 0);
                    default: begin tk = 1'b0; e.ill = 1'b1; end
                endcase
                if (tk) e.nnpc = pc + disp;
            end
            3'd3: begin e.nnpc = pc + disp; e.we = 1'b1; e.sel = 5'd15; e.val = pc; end
            3'd4, 3'd5: begin
                if (tg[1:0] != 2'b00) e.mis = 1'b1;
                else begin
                    e.nnpc = tg;
                    if (k == 3'd4) begin e.we = 1'b1; e.sel = rd; e.val = pc; end
                end
            end
            default: ;
        endcase
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
            kind_i = 3'd3;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid_o) begin
                if (sb.size() == 0) begin
                    check("R9", "unexpected valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, "nnpc", nnpc_o, e.nnpc);
                    check(e.tag, "link_we", {63'd0, link_we_o}, {63'd0, e.we});
                    if (e.we) begin
                        check(e.tag, "link_sel", {59'd0, link_sel_o}, {59'd0, e.sel});
                        check(e.tag, "link_val", link_val_o, e.val);
                    end
                    check(e.tag, "misalign", {63'd0, misalign_o}, {63'd0, e.mis});
                    check(e.tag, "illegal", {63'd0, illegal_o}, {63'd0, e.ill});
                end
            end else begin
                check("R9", "idle strobes", {61'd0, link_we_o, misalign_o, illegal_o}, 64'd0);
            end
        end
    end

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs zero while in reset
        check("R10", "reset state",
              {60'd0, out_valid_o, link_we_o, misalign_o, illegal_o} | nnpc_o | link_val_o, 64'd0);
        rst_n = 1'b1;

        // R1 / R3 / R4 register branch conditions
        send(3'd2, 3'd1, 0, 64'd0,  0, 64'h1000, 64'h1008, 64'h40, 0, "R1_eq_taken_R3");
        send(3'd2, 3'd1, 0, 64'd9,  0, 64'h1000, 64'h1008, 64'h40, 0, "R1_eq_not_R4");
        send(3'd2, 3'd5, 0, 64'd9,  0, 64'h1000, 64'h1008, -64'sd16, 0, "R1_ne_taken");
        send(3'd2, 3'd2, 0, -64'sd1, 0, 64'h2000, 64'h2008, 64'h80, 0, "R1_le_neg");
        send(3'd2, 3'd2, 0, 64'd0,  0, 64'h2000, 64'h2008, 64'h80, 0, "R1_le_zero");
        send(3'd2, 3'd2, 0, 64'd1,  0, 64'h2000, 64'h2008, 64'h80, 0, "R1_le_pos_R4");
        idle(2);
        send(3'd2, 3'd3, 0, 64'h8000_0000_0000_0000, 0, 64'h3000, 64'h3008, 64'h10, 0, "R1_lt_min");
        send(3'd2, 3'd3, 0, 64'd0, 0, 64'h3000, 64'h3008, 64'h10, 0, "R1_lt_zero");
        send(3'd2, 3'd6, 0, 64'd1, 0, 64'h3000, 64'h3008, 64'h10, 0, "R1_gt_one");
        send(3'd2, 3'd6, 0, 64'd0, 0, 64'h3000, 64'h3008, 64'h10, 0, "R1_gt_zero");
        send(3'd2, 3'd6, 0, 64'h7FFF_FFFF_FFFF_FFFF, 0, 64'h3000, 64'h3008, 64'h10, 0, "R1_gt_max");
        send(3'd2, 3'd7, 0, 64'd0, 0, 64'h3000, 64'h3008, 64'h10, 0, "R1_ge_zero");
        send(3'd2, 3'd7, 0, -64'sd5, 0, 64'h3000, 64'h3008, 64'h10, 0, "R1_ge_neg");
        // R2 reserved codes
        send(3'd2, 3'd0, 0, 64'd0, 0, 64'h4000, 64'h4008, 64'h20, 0, "R2_code0");
        send(3'd2, 3'd4, 0, -64'sd3, 0, 64'h4000, 64'h4008, 64'h20, 0, "R2_code4");
        idle(1);
        // R3 / R4 condition-code branches
        send(3'd1, 3'd0, 1, 0, 0, 64'h5000, 64'h5008, -64'sd256, 0, "R3_cc_taken");
        send(3'd1, 3'd0, 0, 0, 0, 64'h5000, 64'h5008, -64'sd256, 0, "R4_cc_not");
        // R5 call
        send(3'd3, 3'd0, 0, 0, 0, 64'h6000, 64'h6008, 64'h1_0000, 5'd3, "R5_call");
        // R6 jump-and-link
        send(3'd4, 3'd0, 0, 64'h7000, 64'h24, 64'h6100, 64'h6108, 0, 5'd9, "R6_jmpl");
        send(3'd4, 3'd0, 0, 64'h7000, -64'sd8, 64'h6100, 64'h6108, 0, 5'd31, "R6_jmpl_negop");
        send(3'd4, 3'd0, 0, 64'h1001, 64'h2, 64'h6200, 64'h6208, 0, 5'd7, "R8_jmpl_low11");
        send(3'd4, 3'd0, 0, 64'h2000, -64'sd2, 64'h6200, 64'h6208, 0, 5'd7, "R8_jmpl_low10");
        // R7 return
        send(3'd5, 3'd0, 0, 64'h8000, 64'h8, 64'h6300, 64'h6308, 0, 5'd1, "R7_ret");
        send(3'd5, 3'd0, 0, 64'h8000, 64'h1, 64'h6300, 64'h6308, 0, 5'd1, "R8_ret_low01");
        idle(1);
        // R11 none and unused kinds
        send(3'd0, 3'd1, 1, 0, 0, 64'h9000, 64'h9008, 64'h40, 0, "R11_none");
        send(3'd7, 3'd1, 1, 0, 0, 64'h9000, 64'h9008, 64'h40, 0, "R11_kind7");
        send(3'd6, 3'd1, 1, 0, 0, 64'h9000, 64'h9008, 64'h40, 0, "R11_kind6");
        idle(4);
        check("R9", "scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule